// File: doc/BRIEF.md
# SHA-2 Message Padding Sequencer

This block sits between a FIFO of message words and a SHA-2 compression core and adds the standard padding to the message stream. Message words go through it unchanged. When the message ends, it emits the 0x80 end marker, then as many zero words as needed, then two words that carry the message length in bits. The marker is placed inside a partial last word if the length ends inside a word. One state machine serves two word widths. The narrow mode uses 32-bit words (SHA-256). The wide mode uses 64-bit words (SHA-384 and SHA-512).

A hash begins with a start pulse and resumes with a resume pulse. A later finish pulse asks for padding once the counted message bits reach the supplied length. A pause pulse instead ends the segment at that length without padding, so a resume can carry on from the same bit count later. Each word is handed to the core with a valid/ready handshake. The FIFO is read in the same cycle that the core accepts a message word.

Top module: `sha2_pad_seq`

## Requirements
- R1: After reset the block is idle. `pad_valid_o` and `fifo_pop_o` stay low, even while the FIFO offers a word.
- R2: `mode_i` is captured on start or resume and set back to none (0) by `done_i`. The encoding is 0 none, 1 narrow (SHA-256), 2 and 3 wide (SHA-384, SHA-512). None behaves as narrow. In wide mode a message padded to the end fills whole 1024-bit blocks, and all 64 bits of each word are carried.
- R3: The block leaves idle only when `enable_i` is high and start or resume is pulsed. A pulse while disabled leaves it idle.
- R4: While receiving, and while the length is not yet reached, `pad_word_o` equals the FIFO word. In narrow mode only the low 32 bits are carried and the upper 32 bits are zero. `pad_valid_o` follows `fifo_valid_i`, and `fifo_pop_o` is `fifo_valid_i & core_ready_i`, all in the same cycle.
- R5: Every word accepted (valid and ready) adds 32 bits to the bit count in narrow mode and 64 bits in wide mode. Start clears the count. Resume keeps it, so a resumed message continues its block alignment.
- R6: Finish and pause are sticky from the cycle after their pulse. Both are cleared by disable, by start or resume, and by done. A finish given in the same cycle as start is lost.
- R7: If the remaining bits are fewer than one word and finish is set, the last word is emitted with its message bytes taken MSB-first. The byte at index (length bits [4:3] narrow, [5:3] wide) becomes 0x80 and the bytes after it are zero. No separate marker word follows.
- R8: If the length is a whole number of words, finish produces a marker word with 0x80 in its top byte, right after the last message word.
- R9: Zero words follow the marker until the next word would fall in the last two word slots of a block (512 bits narrow, 1024 bits wide). A narrow padded message fills whole 512-bit blocks.
- R10: The two length words follow the zero words. Narrow mode sends zero-extended length bits [63:32] and then [31:0]. Wide mode sends bits [127:64] and then [63:0]. After the second one is accepted the block is idle.
- R11: If the count reaches the length while pause is set and finish is not, the block goes idle and emits no padding.
- R12: With `enable_i` low the block is idle from the next cycle, whatever state it was in.
- R13: A marker, zero or length word holds `pad_valid_o` high until the core accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable; low forces idle |
| start_i | input | 1 | Begin a new hash, clears bit count |
| resume_i | input | 1 | Resume a paused hash, keeps bit count |
| finish_i | input | 1 | Request padding at end of message |
| pause_i | input | 1 | End segment at length without padding |
| done_i | input | 1 | Hash complete, clears captured mode |
| mode_i | input | 2 | Digest mode (0 none, 1 narrow, 2/3 wide) |
| msg_bits_i | input | 128 | Message length in bits |
| fifo_word_i | input | 64 | Word at head of message FIFO |
| fifo_valid_i | input | 1 | FIFO head word is valid |
| core_ready_i | input | 1 | Core accepts the offered word |
| pad_word_o | output | 64 | Word offered to the core |
| pad_valid_o | output | 1 | Offered word is valid |
| fifo_pop_o | output | 1 | Remove the FIFO head word |

## Verification
The outputs are combinational in the current state, so a word, its valid flag and the FIFO pop are due in the same cycle as the inputs that cause them. The bench samples them two time units after it drives the inputs, well before the next edge. A state change, a bit count step or a set sticky flag shows up only one edge later. So a finish pulse takes effect in the cycle after it, and disable makes the outputs quiet from the following cycle. The bench's behavioural model advances its own state at each rising edge and predicts the next cycle's outputs with the same one-edge lag. Block alignment, pause word counts and the quiet periods are also checked over whole messages, by counting the words the core accepts.

// File: rtl/sha2pad_pkg.sv
`timescale 1ns/1ps
// Shared types for the SHA-2 padding sequencer.
// Assumes: all modules of the block import this package.
package sha2pad_pkg;

    // Captured digest mode; the encoding is visible on the mode input.
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_S256 = 2'd1,
        MODE_S384 = 2'd2,
        MODE_S512 = 2'd3
    } dmode_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RECV  = 3'd1,
        ST_MARK  = 3'd2,
        ST_ZERO  = 3'd3,
        ST_LENHI = 3'd4,
        ST_LENLO = 3'd5
    } pstate_e;

    // Which kind of word the output mux forms.
    typedef enum logic [2:0] {
        WK_PASS  = 3'd0,
        WK_MERGE = 3'd1,
        WK_MARK  = 3'd2,
        WK_ZERO  = 3'd3,
        WK_LENHI = 3'd4,
        WK_LENLO = 3'd5
    } wkind_e;

endpackage

// File: rtl/sha2_pad_flags.sv
`timescale 1ns/1ps
// Request flags and mode capture.
// Holds the captured digest mode and the sticky finish and pause requests.
// Assumes: go is start|resume; go takes priority over done for the mode.
module sha2_pad_flags
    import sha2pad_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       go_i,
    input  logic       done_i,
    input  logic       finish_i,
    input  logic       pause_i,
    input  logic [1:0] mode_i,
    output logic       finish_q_o,
    output logic       pause_q_o,
    output logic       wide_o
);

    dmode_e mode_q;
    logic   clr_flags;

    assign clr_flags = !enable_i || go_i || done_i;

    // Capture the mode on go, drop it back to none on done.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= MODE_NONE;
        end else if (go_i) begin
            mode_q <= dmode_e'(mode_i);
        end else if (done_i) begin
            mode_q <= MODE_NONE;
        end
    end

    // Sticky finish and pause requests.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            finish_q_o <= 1'b0;
            pause_q_o  <= 1'b0;
        end else if (clr_flags) begin
            finish_q_o <= 1'b0;
            pause_q_o  <= 1'b0;
        end else begin
            if (finish_i) finish_q_o <= 1'b1;
            if (pause_i)  pause_q_o  <= 1'b1;
        end
    end

    assign wide_o = (mode_q == MODE_S384) || (mode_q == MODE_S512);

    a_r2_done_clears_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i && !go_i |=> !wide_o);

    a_r6_go_clears_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |=> !finish_q_o && !pause_q_o);

    a_r6_finish_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        finish_i && enable_i && !go_i && !done_i |=> finish_q_o);

endmodule

// File: rtl/sha2_pad_bitcnt.sv
`timescale 1ns/1ps
// Transmitted-bit counter.
// Counts bits of words accepted by the core, one word width per accept.
// Assumes: clear (start) wins over a step in the same cycle.
module sha2_pad_bitcnt #(
    parameter int CNT_W    = 128,
    parameter int NARROW_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             wide_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] NSTEP = CNT_W'(NARROW_W);
    localparam logic [CNT_W-1:0] WSTEP = CNT_W'(2 * NARROW_W);

    logic [CNT_W-1:0] step_amt;

    assign step_amt = wide_i ? WSTEP : NSTEP;

    // Clear on start, advance by one word width on each accept.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (step_i) begin
            count_o <= count_o + step_amt;
        end
    end

    a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !clear_i |=> count_o == $past(count_o) + (($past(wide_i)) ? WSTEP : NSTEP));

    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> count_o == '0);

    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i && !clear_i |=> $stable(count_o));

endmodule

// File: rtl/sha2_pad_wordmux.sv
`timescale 1ns/1ps
// Output word former.
// Builds the word the core sees: the FIFO word passed through, the last
// partial word with the marker merged in, a marker word, a zero word, or
// one half of the length.
// Assumes: bytes are big-endian inside a word and the length is a whole
// number of bytes. Narrow words sit in the low half of the bus.
module sha2_pad_wordmux
    import sha2pad_pkg::*;
#(
    parameter int NARROW_W = 32
) (
    input  wkind_e                  kind_i,
    input  logic                    wide_i,
    input  logic [2*NARROW_W-1:0]   fifo_word_i,
    input  logic [4*NARROW_W-1:0]   len_i,
    output logic [2*NARROW_W-1:0]   word_o
);

    localparam int DW      = 2 * NARROW_W;
    localparam int LEN_W   = 2 * DW;
    localparam int NB_MAX  = DW / 8;
    localparam int NOFF_HI = $clog2(NARROW_W) - 1;
    localparam int WOFF_HI = $clog2(DW) - 1;

    logic [DW-1:0] act_word;
    int            nbytes;
    int            mark_at;

    // The narrow view keeps only the low half of the FIFO word.
    assign act_word = wide_i ? fifo_word_i : {{(DW-NARROW_W){1'b0}}, fifo_word_i[NARROW_W-1:0]};
    assign nbytes   = wide_i ? NB_MAX : NARROW_W / 8;
    assign mark_at  = wide_i ? int'(len_i[WOFF_HI:3]) : int'(len_i[NOFF_HI:3]);

    // Select and shape the outgoing word.
    always_comb begin
        word_o = '0;
        unique case (kind_i)
            WK_PASS: word_o = act_word;
            WK_MERGE: begin
                for (int j = 0; j < NB_MAX; j++) begin
                    if (j < nbytes) begin
                        if (j < mark_at) begin
                            word_o[(nbytes-1-j)*8 +: 8] = act_word[(nbytes-1-j)*8 +: 8];
                        end else if (j == mark_at) begin
                            word_o[(nbytes-1-j)*8 +: 8] = 8'h80;
                        end
                    end
                end
            end
            WK_MARK:  word_o[(nbytes-1)*8 +: 8] = 8'h80;
            WK_ZERO:  word_o = '0;
            WK_LENHI: word_o = wide_i ? len_i[LEN_W-1:DW]
                                      : {{(DW-NARROW_W){1'b0}}, len_i[2*NARROW_W-1:NARROW_W]};
            WK_LENLO: word_o = wide_i ? len_i[DW-1:0]
                                      : {{(DW-NARROW_W){1'b0}}, len_i[NARROW_W-1:0]};
            default:  word_o = '0;
        endcase
    end

endmodule

// File: rtl/sha2_pad_seq.sv
`timescale 1ns/1ps
// SHA-2 message padding sequencer (top).
// Passes message words from a FIFO to a compression core. It then adds the
// 0x80 marker, zero words and the two length words, in 32-bit or 64-bit
// word mode.
// Assumes: a paused segment ends on a whole block; the length and the mode
// stay stable while a message is in flight.
module sha2_pad_seq
    import sha2pad_pkg::*;
#(
    parameter int NARROW_W = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  enable_i,
    input  logic                  start_i,
    input  logic                  resume_i,
    input  logic                  finish_i,
    input  logic                  pause_i,
    input  logic                  done_i,
    input  logic [1:0]            mode_i,
    input  logic [4*NARROW_W-1:0] msg_bits_i,
    input  logic [2*NARROW_W-1:0] fifo_word_i,
    input  logic                  fifo_valid_i,
    input  logic                  core_ready_i,
    output logic [2*NARROW_W-1:0] pad_word_o,
    output logic                  pad_valid_o,
    output logic                  fifo_pop_o
);

    localparam int DW      = 2 * NARROW_W;
    localparam int LEN_W   = 2 * DW;
    localparam int NBLK    = 16 * NARROW_W;
    localparam int WBLK    = 16 * DW;
    localparam int NBLK_B  = $clog2(NBLK);
    localparam int WBLK_B  = $clog2(WBLK);
    localparam int NOFF_HI = $clog2(NARROW_W) - 1;
    localparam int WOFF_HI = $clog2(DW) - 1;
    localparam logic [WBLK_B-1:0] N_LASTZ  = WBLK_B'(NBLK - 3 * NARROW_W);
    localparam logic [WBLK_B-1:0] N_LENPOS = WBLK_B'(NBLK - 2 * NARROW_W);
    localparam logic [WBLK_B-1:0] W_LASTZ  = WBLK_B'(WBLK - 3 * DW);
    localparam logic [WBLK_B-1:0] W_LENPOS = WBLK_B'(WBLK - 2 * DW);

    pstate_e            state_q, state_nx;
    wkind_e             kind;
    logic               go, wide, fin_q, pause_q, accept;
    logic [LEN_W-1:0]   count, remaining, word_bits;
    logic [WBLK_B-1:0]  blk_pos;
    logic               at_len, partial, merged, at_lastz, at_lenpos;

    assign go     = start_i || resume_i;
    assign accept = pad_valid_o && core_ready_i;

    sha2_pad_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .go_i       (go),
        .done_i     (done_i),
        .finish_i   (finish_i),
        .pause_i    (pause_i),
        .mode_i     (mode_i),
        .finish_q_o (fin_q),
        .pause_q_o  (pause_q),
        .wide_o     (wide)
    );

    sha2_pad_bitcnt #(
        .CNT_W    (LEN_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start_i),
        .step_i  (accept),
        .wide_i  (wide),
        .count_o (count)
    );

    sha2_pad_wordmux #(
        .NARROW_W (NARROW_W)
    ) u_mux (
        .kind_i      (kind),
        .wide_i      (wide),
        .fifo_word_i (fifo_word_i),
        .len_i       (msg_bits_i),
        .word_o      (pad_word_o)
    );

    // Position of the count inside the current block, and the end-of-message tests.
    always_comb begin
        blk_pos   = wide ? count[WBLK_B-1:0]
                         : {{(WBLK_B-NBLK_B){1'b0}}, count[NBLK_B-1:0]};
        word_bits = wide ? LEN_W'(DW) : LEN_W'(NARROW_W);
        remaining = msg_bits_i - count;
        at_len    = (count == msg_bits_i);
        partial   = (msg_bits_i > count) && (remaining < word_bits);
        merged    = wide ? |msg_bits_i[WOFF_HI:3] : |msg_bits_i[NOFF_HI:3];
        at_lastz  = blk_pos == (wide ? W_LASTZ : N_LASTZ);
        at_lenpos = blk_pos == (wide ? W_LENPOS : N_LENPOS);
    end

    // Next state, handshake outputs and word kind.
    always_comb begin
        state_nx    = state_q;
        pad_valid_o = 1'b0;
        fifo_pop_o  = 1'b0;
        kind        = WK_PASS;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_nx = ST_RECV;
            end
            ST_RECV: begin
                if (at_len) begin
                    if (fin_q)        state_nx = ST_MARK;
                    else if (pause_q) state_nx = ST_IDLE;
                end else if (partial) begin
                    kind = WK_MERGE;
                    if (fin_q) begin
                        pad_valid_o = fifo_valid_i;
                        fifo_pop_o  = fifo_valid_i && core_ready_i;
                        if (fifo_valid_i && core_ready_i) state_nx = ST_MARK;
                    end
                end else begin
                    pad_valid_o = fifo_valid_i;
                    fifo_pop_o  = fifo_valid_i && core_ready_i;
                end
            end
            ST_MARK: begin
                kind = WK_MARK;
                if (merged) begin
                    state_nx = at_lenpos ? ST_LENHI : ST_ZERO;
                end else begin
                    pad_valid_o = 1'b1;
                    if (core_ready_i) state_nx = at_lastz ? ST_LENHI : ST_ZERO;
                end
            end
            ST_ZERO: begin
                kind        = WK_ZERO;
                pad_valid_o = 1'b1;
                if (core_ready_i && at_lastz) state_nx = ST_LENHI;
            end
            ST_LENHI: begin
                kind        = WK_LENHI;
                pad_valid_o = 1'b1;
                if (core_ready_i) state_nx = ST_LENLO;
            end
            ST_LENLO: begin
                kind        = WK_LENLO;
                pad_valid_o = 1'b1;
                if (core_ready_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!enable_i) state_nx = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_nx;
    end

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_IDLE |-> !pad_valid_o && !fifo_pop_o);

    a_r4_pop_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop_o |-> pad_valid_o && core_ready_i);

    a_r12_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> state_q == ST_IDLE);

    a_r10_lenlo_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_LENLO && core_ready_i && enable_i |=> state_q == ST_IDLE);

    a_r9_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_ZERO |-> pad_word_o == '0);

    a_r2_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pad_valid_o && !wide |-> pad_word_o[DW-1:NARROW_W] == '0);

    a_r13_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q inside {ST_ZERO, ST_LENHI, ST_LENLO} && !core_ready_i && enable_i
        |=> pad_valid_o);

endmodule

// File: tb/sha2_pad_seq_tb_top.sv
`timescale 1ns/1ps
module sha2_pad_seq_tb_top;

    logic         clk_i = 1'b0;
    logic         rst_ni, enable_i, start_i, resume_i, finish_i, pause_i, done_i;
    logic [1:0]   mode_i;
    logic [127:0] msg_bits_i;
    logic [63:0]  fifo_word_i;
    logic         fifo_valid_i, core_ready_i;
    logic [63:0]  pad_word_o;
    logic         pad_valid_o, fifo_pop_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit ended = 0;
    bit rand_rdy = 0;

    // Reference model state.
    logic [63:0]  fq[$];
    int           m_st;
    logic [127:0] m_cnt;
    int           m_mode;
    bit           m_fin, m_pause;
    int           seg_words;
    bit           prev_hold;

    always #5 clk_i = ~clk_i;

    sha2_pad_seq dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .start_i(start_i),
        .resume_i(resume_i), .finish_i(finish_i), .pause_i(pause_i), .done_i(done_i),
        .mode_i(mode_i), .msg_bits_i(msg_bits_i), .fifo_word_i(fifo_word_i),
        .fifo_valid_i(fifo_valid_i), .core_ready_i(core_ready_i),
        .pad_word_o(pad_word_o), .pad_valid_o(pad_valid_o), .fifo_pop_o(fifo_pop_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock cycle: predict, compare mid-cycle, then advance the model at the edge.
    task automatic run_cycle();
        bit wide, ev, ep, go;
        int w, b, nxt, nb;
        logic [63:0] ew, act, keep;
        string tag;
        fifo_valid_i = fq.size() > 0;
        fifo_word_i  = (fq.size() > 0) ? fq[0] : 64'h0;
        core_ready_i = rand_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
        #2;
        wide = (m_mode == 2) || (m_mode == 3);
        w = wide ? 64 : 32;
        b = wide ? 1024 : 512;
        act = wide ? fifo_word_i : (fifo_word_i & 64'hFFFF_FFFF);
        ev = 0; ep = 0; ew = 64'h0; nxt = m_st; tag = "R3";
        go = start_i || resume_i;
        case (m_st)
            0: if (go) nxt = 1;
            1: begin
                tag = "R4";
                if (msg_bits_i == m_cnt) begin
                    if (m_fin) nxt = 2;
                    else if (m_pause) nxt = 0;
                end else if (msg_bits_i - m_cnt < w) begin
                    tag = "R7";
                    if (m_fin) begin
                        nb = int'((msg_bits_i % w) / 8);
                        keep = 64'hFFFF_FFFF_FFFF_FFFF << (w - 8 * nb);
                        ev = fifo_valid_i; ep = fifo_valid_i && core_ready_i;
                        ew = (act & keep) | (64'h80 << (w - 8 * nb - 8));
                        if (ep) nxt = 2;
                    end
                end else begin
                    ev = fifo_valid_i; ep = fifo_valid_i && core_ready_i; ew = act;
                end
            end
            2: begin
                tag = "R8";
                if (msg_bits_i % w != 0) nxt = (m_cnt % b == b - 2 * w) ? 4 : 3;
                else begin
                    ev = 1; ew = 64'h80 << (w - 8);
                    if (core_ready_i) nxt = (m_cnt % b == b - 3 * w) ? 4 : 3;
                end
            end
            3: begin
                tag = "R9"; ev = 1;
                if (core_ready_i && (m_cnt % b == b - 3 * w)) nxt = 4;
            end
            4: begin
                tag = "R10"; ev = 1;
                ew = wide ? msg_bits_i[127:64] : {32'h0, msg_bits_i[63:32]};
                if (core_ready_i) nxt = 5;
            end
            default: begin
                tag = "R10"; ev = 1;
                ew = wide ? msg_bits_i[63:0] : {32'h0, msg_bits_i[31:0]};
                if (core_ready_i) nxt = 0;
            end
        endcase
        if (!enable_i) nxt = 0;
        if (prev_hold) chk(pad_valid_o == 1'b1, "R13", {63'h0, pad_valid_o}, 64'h1);
        chk({pad_valid_o, fifo_pop_o} == {ev, ep}, tag, {62'h0, pad_valid_o, fifo_pop_o}, {62'h0, ev, ep});
        if (ev) chk(pad_word_o == ew, tag, pad_word_o, ew);
        if (pad_valid_o && core_ready_i) seg_words++;
        prev_hold = (m_st >= 3) && ev && !core_ready_i && enable_i;
        @(posedge clk_i);
        if (start_i) m_cnt = '0;
        else if (ev && core_ready_i) m_cnt = m_cnt + w;
        if (ep) void'(fq.pop_front());
        if (!enable_i || go || done_i) begin
            m_fin = 0; m_pause = 0;
        end else begin
            if (finish_i) m_fin = 1;
            if (pause_i) m_pause = 1;
        end
        if (go) m_mode = int'(mode_i);
        else if (done_i) m_mode = 0;
        m_st = nxt;
        #1;
        start_i = 0; resume_i = 0; finish_i = 0; pause_i = 0; done_i = 0;
        cyc++;
    endtask

    task automatic push_words(input int n);
        for (int k = 0; k < n; k++)
            fq.push_back(64'hC3A5_0F1E_7B29_D640 ^ (64'(fq.size() + k + cyc) * 64'h0102_0304_0506_0708));
    endtask

    // Send one message segment and run it to idle.
    task automatic send_msg(input int mode, input longint bits, input int nwords,
                            input bit resume, input bit use_pause);
        int wbits;
        mode_i = 2'(mode);
        msg_bits_i = 128'(bits);
        push_words(nwords);
        seg_words = 0;
        if (resume) resume_i = 1; else start_i = 1;
        run_cycle();
        if (use_pause) pause_i = 1; else finish_i = 1;
        run_cycle();
        for (int k = 0; k < 3000 && m_st != 0; k++) run_cycle();
        wbits = (mode >= 2) ? 64 : 32;
        if (use_pause)
            chk(seg_words == nwords, "R11", 64'(seg_words), 64'(nwords));
        else if (mode >= 2)
            chk((seg_words * wbits) % 1024 == 0, "R2", 64'(seg_words), 64'(seg_words + 16 - seg_words % 16));
        else
            chk((seg_words * wbits) % 512 == 0, "R9", 64'(seg_words), 64'(seg_words + 16 - seg_words % 16));
        run_cycle();
        chk(pad_valid_o == 1'b0, use_pause ? "R11" : "R10", {63'h0, pad_valid_o}, 64'h0);
    endtask

    initial begin
        rst_ni = 0; enable_i = 1; start_i = 0; resume_i = 0; finish_i = 0; pause_i = 0;
        done_i = 0; mode_i = 2'd1; msg_bits_i = '0; fifo_word_i = '0; fifo_valid_i = 0;
        core_ready_i = 1;
        m_st = 0; m_cnt = '0; m_mode = 0; m_fin = 0; m_pause = 0; prev_hold = 0;
        repeat (3) @(posedge clk_i);
        #1;
        rst_ni = 1;
        // R1: idle after reset even with a word waiting.
        push_words(1);
        run_cycle();
        chk(pad_valid_o == 0 && fifo_pop_o == 0, "R1", {62'h0, pad_valid_o, fifo_pop_o}, 64'h0);
        fq.delete();
        rand_rdy = 1;

        send_msg(1, 0, 0, 0, 0);        // empty message, narrow
        done_i = 1; run_cycle();
        send_msg(1, 192, 6, 0, 0);      // whole words
        send_msg(1, 56, 2, 0, 0);       // partial word, marker at byte 3
        send_msg(1, 448, 14, 0, 0);     // spills into a second block
        send_msg(1, 424, 14, 0, 0);     // merged marker lands just before length
        send_msg(3, 104, 2, 0, 0);      // wide partial, marker at byte 5
        send_msg(2, 896, 14, 0, 0);     // wide, two blocks
        send_msg(3, 832, 13, 0, 0);     // wide marker straight to length

        // R11 then R5: pause one block, resume keeps the count.
        send_msg(1, 512, 16, 0, 1);
        send_msg(1, 1064, 18, 1, 0);
        chk(seg_words == 32, "R5", 64'(seg_words), 64'd32);

        // R6: finish together with start is lost; block waits at the length.
        mode_i = 2'd1; msg_bits_i = 128'd64; push_words(2);
        start_i = 1; finish_i = 1; run_cycle();
        repeat (12) run_cycle();
        chk(pad_valid_o == 0, "R6", {63'h0, pad_valid_o}, 64'h0);
        finish_i = 1; run_cycle();
        for (int k = 0; k < 200 && m_st != 0; k++) run_cycle();
        chk(m_st == 0 && pad_valid_o == 0, "R6", {63'h0, pad_valid_o}, 64'h0);

        // R12: disable in mid-message.
        mode_i = 2'd1; msg_bits_i = 128'd320; push_words(10);
        start_i = 1; run_cycle();
        finish_i = 1; run_cycle();
        repeat (4) run_cycle();
        enable_i = 0; run_cycle();
        run_cycle();
        chk(pad_valid_o == 0 && fifo_pop_o == 0, "R12", {62'h0, pad_valid_o, fifo_pop_o}, 64'h0);
        fq.delete();

        // R3: go while disabled is ignored.
        start_i = 1; run_cycle();
        enable_i = 1; push_words(2);
        repeat (3) run_cycle();
        chk(pad_valid_o == 0 && fifo_pop_o == 0, "R3", {62'h0, pad_valid_o, fifo_pop_o}, 64'h0);
        fq.delete();

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    always @(posedge clk_i) begin
        if (cyc > 100000 && !ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule